// File: doc/BRIEF.md
# Threshold Offset Load Sequencer

This unit keeps the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against the pointer difference. Each offset is split into a low part, which is as wide as the data bus, and a high part, which holds only the bits the configured address width still needs. A single data port loads all four parts. While the surrounding control reports that load mode is active, every accepted write stores the input word into the next part of a fixed circular sequence. Every accepted read places the next part of a separate circular sequence on a registered data output.

Both sequence positions are kept when load mode is released, so a later load session carries on where the last one stopped. The complete empty offset and full offset are always visible as parallel outputs for the flag comparators. Deciding when load mode is active, and the FIFO storage itself, belong to the surrounding logic. The unit works in one clock domain, which is the case where the write and read clocks are tied together.

Top module: `ofs_load_seq`

## Requirements
- R1: After synchronous reset, both low parts hold 7, both high parts hold 0, `dout` is 0, and `empty_ofs` and `full_ofs` both equal 7.
- R2: While `load_mode` and `wr_en` are both high, each rising clock edge writes `din` into the part selected by the write position. The positions are 0 = empty low, 1 = empty high, 2 = full low, 3 = full high. The write position then advances by one, and the new value shows on `empty_ofs` or `full_ofs` from the following cycle.
- R3: The write that follows a write to the full-high part goes to the empty-low part again.
- R4: A write request while `load_mode` is low changes no offset and does not move the write position. A later load write continues at the position where the previous one stopped.
- R5: A high part keeps only `din[HI_W-1:0]`, where HI_W = ADDR_W - DATA_W. The output offsets are `{high, low}`, and a high part read back carries zeros above bit HI_W-1.
- R6: While `load_mode` and `rd_en` are both high and `wr_en` is low, each rising edge loads the part at the read position into `dout` and advances the read position. The read position uses the same 0..3 coding as the write position.
- R7: The read position wraps from the full-high part to the empty-low part, and it moves independently of the write position.
- R8: When a load write and a load read are requested in the same cycle, the write is carried out, `dout` holds, and the read position does not move.
- R9: Reset returns both positions to the empty-low part, even in the middle of a sequence.
- R10: In any cycle without an accepted read, including `rd_en` high while `load_mode` is low, `dout` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the write and read sides |
| rst | input | 1 | Synchronous active-high reset |
| load_mode | input | 1 | High while the offset registers are being accessed |
| wr_en | input | 1 | Write request for the offset registers |
| rd_en | input | 1 | Read request for the offset registers (both read enables combined) |
| din | input | DATA_W | Word to store into the current offset part |
| dout | output | DATA_W | Registered read-back of an offset part |
| empty_ofs | output | ADDR_W | Complete almost-empty offset, {high, low} |
| full_ofs | output | ADDR_W | Complete almost-full offset, {high, low} |

## Verification
The bench builds the unit with DATA_W = 9 and ADDR_W = 12, which leaves high parts of only three bits. With that narrow high part, the masking of written high bits and the zero fill on read-back show up with ordinary data words such as 0x1FF. A behavioural model of the four parts and both positions predicts every cycle's `dout`, and the bench checks the parallel offsets at the end of each phase. The stimulus runs past the wrap of both positions and splits load sessions at odd positions. It also sends requests while load mode is inactive, applies a same-cycle write and read, and resets in the middle of a sequence.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  typedef enum logic [1:0] {
    SLOT_E_LO = 2'd0,
    SLOT_E_HI = 2'd1,
    SLOT_F_LO = 2'd2,
    SLOT_F_HI = 2'd3
  } slot_e;

  localparam int LO_RESET_VAL = 7;

endpackage

// File: rtl/ofs_slot_ptr.sv
module ofs_slot_ptr
  import ofs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  output slot_e slot
);

  logic [1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= 2'd0;
    else if (adv) cnt_q <= cnt_q + 2'd1;
  end

  assign slot = slot_e'(cnt_q);

  p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
    adv |=> (cnt_q == $past(cnt_q) + 2'd1));

  p_ptr_keep_r4: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt_q));

endmodule

// File: rtl/ofs_bank.sv
module ofs_bank
  import ofs_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int HI_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  slot_e             wslot,
  input  logic [DATA_W-1:0] wdata,
  input  slot_e             rslot,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] e_lo,
  output logic [HI_W-1:0]   e_hi,
  output logic [DATA_W-1:0] f_lo,
  output logic [HI_W-1:0]   f_hi
);

  localparam int PAD_W = DATA_W - HI_W;

  logic [DATA_W-1:0] lo_q [2];
  logic [HI_W-1:0]   hi_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_side
    localparam logic [1:0] LO_IDX = 2'(2 * g);
    localparam logic [1:0] HI_IDX = 2'(2 * g + 1);

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[g] <= DATA_W'(LO_RESET_VAL);
        hi_q[g] <= '0;
      end else if (we) begin
        if (wslot == slot_e'(LO_IDX)) lo_q[g] <= wdata;
        if (wslot == slot_e'(HI_IDX)) hi_q[g] <= wdata[HI_W-1:0];
      end
    end
  end

  always_comb begin
    unique case (rslot)
      SLOT_E_LO: rdata = lo_q[0];
      SLOT_E_HI: rdata = {{PAD_W{1'b0}}, hi_q[0]};
      SLOT_F_LO: rdata = lo_q[1];
      SLOT_F_HI: rdata = {{PAD_W{1'b0}}, hi_q[1]};
      default:   rdata = '0;
    endcase
  end

  assign e_lo = lo_q[0];
  assign e_hi = hi_q[0];
  assign f_lo = lo_q[1];
  assign f_hi = hi_q[1];

  p_hi_mask_r5: assert property (@(posedge clk) disable iff (rst)
    (we && wslot == SLOT_E_HI) |=> (hi_q[0] == $past(wdata[HI_W-1:0])));

  p_untouched_r2: assert property (@(posedge clk) disable iff (rst)
    (we && wslot != SLOT_E_LO) |=> $stable(lo_q[0]));

endmodule

// File: rtl/ofs_load_seq.sv
module ofs_load_seq
  import ofs_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_mode,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [ADDR_W-1:0] empty_ofs,
  output logic [ADDR_W-1:0] full_ofs
);

  // high part width; the design assumes 0 < HI_W < DATA_W
  localparam int HI_W = ADDR_W - DATA_W;

  logic              wr_fire, rd_fire;
  slot_e             wslot, rslot;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] e_lo, f_lo;
  logic [HI_W-1:0]   e_hi, f_hi;

  // a write wins over a read requested in the same cycle
  assign wr_fire = load_mode && wr_en;
  assign rd_fire = load_mode && rd_en && !wr_en;

  ofs_slot_ptr u_wptr (
    .clk  (clk),
    .rst  (rst),
    .adv  (wr_fire),
    .slot (wslot)
  );

  ofs_slot_ptr u_rptr (
    .clk  (clk),
    .rst  (rst),
    .adv  (rd_fire),
    .slot (rslot)
  );

  ofs_bank #(
    .DATA_W (DATA_W),
    .HI_W   (HI_W)
  ) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_fire),
    .wslot (wslot),
    .wdata (din),
    .rslot (rslot),
    .rdata (rd_word),
    .e_lo  (e_lo),
    .e_hi  (e_hi),
    .f_lo  (f_lo),
    .f_hi  (f_hi)
  );

  always_ff @(posedge clk) begin
    if (rst)          dout <= '0;
    else if (rd_fire) dout <= rd_word;
  end

  assign empty_ofs = {e_hi, e_lo};
  assign full_ofs  = {f_hi, f_lo};

  p_wr_priority_r8: assert property (@(posedge clk) disable iff (rst)
    (load_mode && wr_en && rd_en) |=> $stable(dout));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(load_mode && rd_en) |=> $stable(dout));

  p_hi_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && (rslot == SLOT_E_HI || rslot == SLOT_F_HI))
      |=> (dout[DATA_W-1:HI_W] == '0));

  p_rd_step_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && rslot == SLOT_F_HI) |=> (rslot == SLOT_E_LO));

endmodule

// File: tb/sim_ofs_load_seq.sv
module sim_ofs_load_seq;

  localparam int DW   = 9;
  localparam int AW   = 12;
  localparam int HW   = AW - DW;
  localparam int HMSK = (1 << HW) - 1;

  typedef struct {
    logic [DW-1:0] val;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_mode = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic [AW-1:0] empty_ofs, full_ofs;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  exp_t          sb_q [$];
  int            m_reg [4];
  int            m_wp, m_rp;
  logic [DW-1:0] m_dout;

  always #2 clk = ~clk;

  ofs_load_seq #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk       (clk),
    .rst       (rst),
    .load_mode (load_mode),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .din       (din),
    .dout      (dout),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs)
  );

  task automatic model_reset();
    m_reg[0] = 7; m_reg[1] = 0; m_reg[2] = 7; m_reg[3] = 0;
    m_wp = 0; m_rp = 0; m_dout = '0;
  endtask

  // driver: one cycle of stimulus, updates the model, pushes expected dout
  task automatic step(input bit r, input bit lm, input bit we, input bit re,
                      input int d, input string req);
    exp_t it;
    @(negedge clk);
    rst = r; load_mode = lm; wr_en = we; rd_en = re; din = DW'(d);
    if (r) begin
      model_reset();
    end else if (lm && we) begin
      m_reg[m_wp] = (m_wp % 2 == 1) ? (d & HMSK) : (d & ((1 << DW) - 1));
      m_wp = (m_wp + 1) % 4;
    end else if (lm && re) begin
      m_dout = DW'(m_reg[m_rp]);
      m_rp = (m_rp + 1) % 4;
    end
    it.val = m_dout;
    it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: compares dout after each edge against the queued expectation
  always @(posedge clk) begin
    exp_t it;
    #1;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      n_chk++;
      if (dout !== it.val) begin
        n_fail++;
        $display("FAIL %s dout actual=%h expected=%h", it.req, dout, it.val);
      end
    end
  end

  task automatic chk_ofs(input string req);
    logic [AW-1:0] ee, fe;
    @(negedge clk);
    ee = {HW'(m_reg[1]), DW'(m_reg[0])};
    fe = {HW'(m_reg[3]), DW'(m_reg[2])};
    n_chk++;
    if (empty_ofs !== ee || full_ofs !== fe) begin
      n_fail++;
      $display("FAIL %s empty/full actual=%h/%h expected=%h/%h",
               req, empty_ofs, full_ofs, ee, fe);
    end
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    step(1, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, "R1");
    idle("R1");
    chk_ofs("R1");

    // read back defaults: 7,0,7,0 then wrap to 7
    step(0, 1, 0, 1, 0, "R6");
    step(0, 1, 0, 1, 0, "R6");
    step(0, 1, 0, 1, 0, "R6");
    step(0, 1, 0, 1, 0, "R6");
    step(0, 1, 0, 1, 0, "R7");
    idle("R10");

    // full write sequence, high parts masked to three bits
    step(0, 1, 1, 0, 'h1A5, "R2");
    step(0, 1, 1, 0, 'h1FF, "R5");
    step(0, 1, 1, 0, 'h0C3, "R2");
    step(0, 1, 1, 0, 'h002, "R2");
    idle("R10");
    chk_ofs("R2");
    chk_ofs("R5");

    // fifth write wraps to empty low
    step(0, 1, 1, 0, 'h011, "R3");
    idle("R10");
    chk_ofs("R3");

    // writes outside load mode are ignored, position retained
    step(0, 0, 1, 0, 'h155, "R4");
    step(0, 0, 1, 0, 'h0AA, "R4");
    chk_ofs("R4");
    step(0, 1, 1, 0, 'h006, "R4");
    idle("R4");
    step(0, 1, 1, 0, 'h123, "R4");
    idle("R4");
    chk_ofs("R4");

    // read request outside load mode: dout holds
    step(0, 0, 0, 1, 0, "R10");
    step(0, 0, 0, 1, 0, "R10");

    // read position continues at empty high, masked value read back
    step(0, 1, 0, 1, 0, "R5");
    step(0, 1, 0, 1, 0, "R7");

    // same-cycle write and read: write wins, read holds
    step(0, 1, 1, 1, 'h0FE, "R8");
    step(0, 1, 1, 1, 'h1C4, "R8");
    idle("R8");
    chk_ofs("R8");
    step(0, 1, 0, 1, 0, "R8");
    step(0, 1, 0, 1, 0, "R7");
    step(0, 1, 0, 1, 0, "R6");

    // reset mid-sequence restores defaults and positions
    step(0, 1, 1, 0, 'h0EE, "R9");
    step(1, 0, 0, 0, 0, "R9");
    idle("R9");
    chk_ofs("R9");
    step(0, 1, 0, 1, 0, "R9");
    step(0, 1, 1, 0, 'h0B0, "R9");
    idle("R9");
    chk_ofs("R9");

    idle("R10");
    idle("R10");
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule